// File: doc/BRIEF.md
# Packet Segment Transmit Ingress

This block is the user-facing entry of a packet transmit path. User logic presents packet segments on a wide local bus: a data word, a channel number, start and end markers, an error flag and a count of empty bytes. A segment is taken only in cycles where the enable input is high. Every accepted segment goes into a segment FIFO. A downstream transmit engine drains that FIFO one segment per cycle using a valid/ready handshake.

The block applies backpressure with a ready output. Ready falls while the FIFO has fewer free entries than a configurable margin, so a user that reacts a few cycles late still has room. A user that writes while ready is low sets a sticky overflow flag. Once the FIFO is completely full, further segments are dropped. The block also keeps start/end framing state for each channel and sets a sticky framing-error flag when a channel's segment order is broken. One clear input resets both sticky flags.

Top module: `pktin_tx_ingress`

## Requirements
- R1: In cycles where `tx_en_i` is 0, every other transmit input is ignored: nothing is stored and neither sticky flag changes.
- R2: An enabled segment that arrives while the FIFO is not full is stored. Stored segments leave in arrival order. `seg_valid_o` is 1 on the clock edge after a write into an empty FIFO.
- R3: `tx_ready_o` is 1 exactly when the number of free FIFO entries is at least `READY_MARGIN`. With DEPTH=16 and READY_MARGIN=4, this means when 12 or fewer segments are held.
- R4: An enabled write while `tx_ready_o` is 0 sets `ovf_o` on the following edge. The flag then stays 1 until cleared. If a violation and `flag_clr_i` fall in the same cycle, the flag stays set.
- R5: An enabled segment that arrives while the FIFO holds DEPTH entries is dropped. It never appears on the read side.
- R6: Framing is tracked for each channel. `frame_err_o` is set when a start (`tx_sop_i`=1) arrives on a channel whose packet is still open. It is also set when a non-start segment arrives on a channel with no open packet. A segment with both start and end set is a legal single-segment packet. Packets on different channels may interleave.
- R7: A stored segment whose end marker is 0 carries error 0 and empty count 0 on the read side. The error flag and the empty count given with the final segment pass through unchanged. Byte 0 is the most significant byte of the data word, so the empty bytes are the least significant ones.
- R8: A segment is removed only in a cycle where `seg_valid_o` and `seg_ready_i` are both 1. While `seg_ready_i` is 0, the presented segment holds steady.
- R9: A 1 on `flag_clr_i`, with no new violation in that cycle, makes `ovf_o` and `frame_err_o` 0 on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Qualifies all transmit inputs in this cycle |
| tx_data_i | input | DATA_W | Segment data, byte 0 in the top byte |
| tx_chan_i | input | CHAN_W | Channel number |
| tx_sop_i | input | 1 | First segment of a packet |
| tx_eop_i | input | 1 | Last segment of a packet |
| tx_err_i | input | 1 | Packet error, meaningful only with end |
| tx_mty_i | input | MTY_W | Empty bytes in final segment |
| flag_clr_i | input | 1 | Clears both sticky flags |
| tx_ready_o | output | 1 | Backpressure: writing is allowed |
| ovf_o | output | 1 | Sticky: write while not ready |
| frame_err_o | output | 1 | Sticky: framing rule broken |
| seg_valid_o | output | 1 | A segment is presented |
| seg_ready_i | input | 1 | Consumer takes the presented segment |
| seg_data_o | output | DATA_W | Presented data |
| seg_chan_o | output | CHAN_W | Presented channel |
| seg_sop_o | output | 1 | Presented start marker |
| seg_eop_o | output | 1 | Presented end marker |
| seg_err_o | output | 1 | Presented error flag |
| seg_mty_o | output | MTY_W | Presented empty count |

## Verification
Every result is due one edge after its stimulus. That covers a stored segment appearing at the read side, a pop clearing it, ready moving with the fill level, and both sticky flags setting or clearing. The bench drives inputs just after a falling edge. It checks just after the next falling edge, which is half a cycle after the rising edge that registered the change. Each scenario task then checks at that point before it drives anything new. Dropped and ignored segments are confirmed by draining the FIFO and comparing the exact sequence and count that come out.

// File: rtl/pktin_pkg.sv
package pktin_pkg;

   typedef struct packed {
      logic sop;
      logic eop;
      logic err;
   } seg_ctl_t;

   typedef enum logic [1:0] {
      FR_OK        = 2'd0,
      FR_REOPEN    = 2'd1,
      FR_ORPHAN    = 2'd2
   } frame_verdict_e;

   // error is only meaningful with the end marker
   function automatic seg_ctl_t clean_ctl(input logic sop, input logic eop, input logic err);
      seg_ctl_t c;
      c.sop = sop;
      c.eop = eop;
      c.err = err & eop;
      return c;
   endfunction

endpackage

// File: rtl/pktin_frame_chk.sv
module pktin_frame_chk
   import pktin_pkg::*;
#(
   parameter int CHAN_W   = 8,
   parameter bit PER_CHAN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [CHAN_W-1:0] chan,
   input  logic              sop,
   input  logic              eop,
   output logic              viol
);

   localparam int NCH = 1 << CHAN_W;

   frame_verdict_e verdict;
   logic           open_cur;
   logic           open_nxt;

   if (CHAN_W < 1 || CHAN_W > 12) begin : g_bad_chan
      $error("pktin_frame_chk: CHAN_W out of range");
   end

   always_comb begin
      if (sop && open_cur)        verdict = FR_REOPEN;
      else if (!sop && !open_cur) verdict = FR_ORPHAN;
      else                        verdict = FR_OK;
      // a packet is left open after a start without end, or a middle segment
      open_nxt = (sop || open_cur) && !eop;
   end

   assign viol = en && (verdict != FR_OK);

   if (PER_CHAN) begin : g_per_chan
      logic [NCH-1:0] open_q;
      assign open_cur = open_q[chan];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  open_q <= '0;
         else if (en) open_q[chan] <= open_nxt;
      end
   end else begin : g_single
      logic open_q;
      logic unused_chan;
      assign unused_chan = ^chan;
      assign open_cur = open_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)  open_q <= 1'b0;
         else if (en) open_q <= open_nxt;
      end
   end

   // R6: a non-start segment on a closed channel is always flagged
   p_orphan_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (en && !sop && !open_cur) |-> viol);

endmodule

// File: rtl/pktin_flags.sv
module pktin_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic set_ovf,
   input  logic set_ferr,
   input  logic clr,
   output logic ovf,
   output logic ferr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovf  <= 1'b0;
         ferr <= 1'b0;
      end else begin
         ovf  <= set_ovf  || (ovf  && !clr);
         ferr <= set_ferr || (ferr && !clr);
      end
   end

   p_ovf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_ovf |=> ovf);
   p_ovf_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !clr) |=> ovf);
   p_ferr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ferr && !clr) |=> ferr);
   p_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !set_ovf && !set_ferr) |=> (!ovf && !ferr));

endmodule

// File: rtl/pktin_seg_fifo.sv
module pktin_seg_fifo #(
   parameter int W      = 8,
   parameter int DEPTH  = 16,
   parameter int MARGIN = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_req,
   input  logic [W-1:0] wr_data,
   output logic         wr_room,
   output logic         rd_valid,
   input  logic         rd_ready,
   output logic [W-1:0] rd_data
);

   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CNT_W = $clog2(DEPTH + 1);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] FILL_LIM = CNT_W'(DEPTH - MARGIN);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("pktin_seg_fifo: DEPTH must be a power of two of at least 2");
   end
   if (MARGIN < 1 || MARGIN > DEPTH) begin : g_bad_margin
      $error("pktin_seg_fifo: MARGIN must be within 1..DEPTH");
   end

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic [CNT_W-1:0] count;
   logic             full;
   logic             wr_fire;
   logic             rd_fire;

   assign full     = (count == FULL_CNT);
   assign wr_fire  = wr_req && !full;
   assign rd_valid = (count != '0);
   assign rd_fire  = rd_valid && rd_ready;
   assign rd_data  = mem[rd_ptr];
   assign wr_room  = (count <= FILL_LIM);

   always_ff @(posedge clk) begin
      if (wr_fire) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (wr_fire) wr_ptr <= wr_ptr + 1'b1;
         if (rd_fire) rd_ptr <= rd_ptr + 1'b1;
         case ({wr_fire, rd_fire})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   p_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      count <= FULL_CNT);
   p_idle_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_req && !rd_fire) |=> $stable(count));
   p_full_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !rd_ready) |=> full);
   p_out_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

endmodule

// File: rtl/pktin_tx_ingress.sv
module pktin_tx_ingress
   import pktin_pkg::*;
#(
   parameter int DATA_W       = 512,
   parameter int CHAN_W       = 8,
   parameter int DEPTH        = 16,
   parameter int READY_MARGIN = 4,
   parameter bit PER_CHAN     = 1'b1,
   localparam int MTY_W       = $clog2(DATA_W / 8)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_en_i,
   input  logic [DATA_W-1:0] tx_data_i,
   input  logic [CHAN_W-1:0] tx_chan_i,
   input  logic              tx_sop_i,
   input  logic              tx_eop_i,
   input  logic              tx_err_i,
   input  logic [MTY_W-1:0]  tx_mty_i,
   input  logic              flag_clr_i,
   output logic              tx_ready_o,
   output logic              ovf_o,
   output logic              frame_err_o,
   output logic              seg_valid_o,
   input  logic              seg_ready_i,
   output logic [DATA_W-1:0] seg_data_o,
   output logic [CHAN_W-1:0] seg_chan_o,
   output logic              seg_sop_o,
   output logic              seg_eop_o,
   output logic              seg_err_o,
   output logic [MTY_W-1:0]  seg_mty_o
);

   localparam int CTL_W = $bits(seg_ctl_t);
   localparam int SEG_W = DATA_W + CHAN_W + MTY_W + CTL_W;

   if (DATA_W < 16 || (DATA_W % 8) != 0 || ((DATA_W / 8) & (DATA_W / 8 - 1)) != 0) begin : g_bad_data
      $error("pktin_tx_ingress: DATA_W must be a power-of-two number of bytes");
   end

   seg_ctl_t         in_ctl;
   seg_ctl_t         out_ctl;
   logic [MTY_W-1:0] in_mty;
   logic [SEG_W-1:0] wr_seg;
   logic [SEG_W-1:0] rd_seg;
   logic             room;
   logic             frame_viol;

   assign in_ctl = clean_ctl(tx_sop_i, tx_eop_i, tx_err_i);
   assign in_mty = tx_eop_i ? tx_mty_i : '0;
   assign wr_seg = {tx_data_i, tx_chan_i, in_mty, in_ctl};

   pktin_seg_fifo #(
      .W      (SEG_W),
      .DEPTH  (DEPTH),
      .MARGIN (READY_MARGIN)
   ) u_fifo (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_req   (tx_en_i),
      .wr_data  (wr_seg),
      .wr_room  (room),
      .rd_valid (seg_valid_o),
      .rd_ready (seg_ready_i),
      .rd_data  (rd_seg)
   );

   pktin_frame_chk #(
      .CHAN_W   (CHAN_W),
      .PER_CHAN (PER_CHAN)
   ) u_frame (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (tx_en_i),
      .chan  (tx_chan_i),
      .sop   (tx_sop_i),
      .eop   (tx_eop_i),
      .viol  (frame_viol)
   );

   pktin_flags u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .set_ovf  (tx_en_i && !room),
      .set_ferr (frame_viol),
      .clr      (flag_clr_i),
      .ovf      (ovf_o),
      .ferr     (frame_err_o)
   );

   assign tx_ready_o = room;
   assign {seg_data_o, seg_chan_o, seg_mty_o, out_ctl} = rd_seg;
   assign seg_sop_o = out_ctl.sop;
   assign seg_eop_o = out_ctl.eop;
   assign seg_err_o = out_ctl.err;

   p_nonfinal_clean_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_valid_o && !seg_eop_o) |-> (seg_mty_o == '0 && !seg_err_o));
   p_ovf_on_violation_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en_i && !tx_ready_o) |=> ovf_o);

endmodule

// File: tb/pktin_tx_ingress_test.sv
module pktin_tx_ingress_test;

   localparam int DW = 512;
   localparam int CW = 8;
   localparam int MW = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tx_en = 1'b0;
   logic [DW-1:0] tx_data = '0;
   logic [CW-1:0] tx_chan = '0;
   logic          tx_sop = 1'b0;
   logic          tx_eop = 1'b0;
   logic          tx_err = 1'b0;
   logic [MW-1:0] tx_mty = '0;
   logic          clr = 1'b0;
   logic          tx_ready, ovf, ferr;
   logic          seg_valid;
   logic          seg_ready = 1'b0;
   logic [DW-1:0] seg_data;
   logic [CW-1:0] seg_chan;
   logic          seg_sop, seg_eop, seg_err;
   logic [MW-1:0] seg_mty;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   pktin_tx_ingress uut (
      .clk(clk), .rst_n(rst_n), .tx_en_i(tx_en), .tx_data_i(tx_data),
      .tx_chan_i(tx_chan), .tx_sop_i(tx_sop), .tx_eop_i(tx_eop),
      .tx_err_i(tx_err), .tx_mty_i(tx_mty), .flag_clr_i(clr),
      .tx_ready_o(tx_ready), .ovf_o(ovf), .frame_err_o(ferr),
      .seg_valid_o(seg_valid), .seg_ready_i(seg_ready), .seg_data_o(seg_data),
      .seg_chan_o(seg_chan), .seg_sop_o(seg_sop), .seg_eop_o(seg_eop),
      .seg_err_o(seg_err), .seg_mty_o(seg_mty)
   );

   function automatic logic [DW-1:0] pat(input int k);
      return {16{32'hC3A50000 + 32'(k)}};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic chk_data(input string req, input int k);
      total++;
      if (seg_data !== pat(k)) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h", req, seg_data[31:0], pat(k) & 32'hFFFFFFFF);
      end
   endtask

   // drive one enabled segment through one rising edge; returns after the next falling edge
   task automatic push(input int ch, input bit s, input bit e, input bit er,
                       input int mt, input int k, input bit c);
      tx_en = 1'b1; tx_chan = CW'(ch); tx_sop = s; tx_eop = e; tx_err = er;
      tx_mty = MW'(mt); tx_data = pat(k); clr = c;
      @(negedge clk);
      tx_en = 1'b0; tx_sop = 1'b0; tx_eop = 1'b0; tx_err = 1'b0; tx_mty = '0;
      tx_data = '0; clr = 1'b0;
   endtask

   task automatic clear_flags();
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   task automatic pop_check(input string req, input int ch, input bit s, input bit e,
                            input bit er, input int mt, input int k);
      chk({req, " valid"}, 64'(seg_valid), 64'd1);
      chk({req, " chan"}, 64'(seg_chan), 64'(ch));
      chk({req, " sop/eop"}, 64'({seg_sop, seg_eop}), 64'({s, e}));
      chk({req, " err"}, 64'(seg_err), 64'(er));
      chk({req, " mty"}, 64'(seg_mty), 64'(mt));
      chk_data({req, " data"}, k);
      seg_ready = 1'b1;
      @(negedge clk);
      seg_ready = 1'b0;
   endtask

   task automatic t_reset();
      chk("R3 reset ready", 64'(tx_ready), 64'd1);
      chk("R8 reset valid", 64'(seg_valid), 64'd0);
      chk("R4 reset ovf", 64'(ovf), 64'd0);
      chk("R6 reset ferr", 64'(ferr), 64'd0);
   endtask

   task automatic t_single();
      push(5, 1, 1, 1, 10, 1, 0);
      chk("R2 valid after write", 64'(seg_valid), 64'd1);
      chk("R6 single segment legal", 64'(ferr), 64'd0);
      pop_check("R7 final fields kept", 5, 1, 1, 1, 10, 1);
      chk("R8 popped empty", 64'(seg_valid), 64'd0);
   endtask

   task automatic t_enable_low();
      // garbage with enable low: an orphan segment that would flag framing if taken
      tx_en = 1'b0; tx_chan = 8'd77; tx_eop = 1'b1; tx_sop = 1'b0; tx_data = pat(55);
      repeat (3) @(negedge clk);
      tx_eop = 1'b0; tx_data = '0;
      chk("R1 nothing stored", 64'(seg_valid), 64'd0);
      chk("R1 no framing flag", 64'(ferr), 64'd0);
      chk("R1 no overflow flag", 64'(ovf), 64'd0);
   endtask

   task automatic t_multi();
      push(2, 1, 0, 0, 0, 20, 0);
      push(2, 0, 0, 1, 7, 21, 0);
      push(2, 0, 1, 0, 3, 22, 0);
      chk("R6 multi framing ok", 64'(ferr), 64'd0);
      // R8 hold while not taken
      @(negedge clk);
      chk("R8 still valid", 64'(seg_valid), 64'd1);
      chk_data("R8 held data", 20);
      pop_check("R2 first", 2, 1, 0, 0, 0, 20);
      pop_check("R7 middle cleaned", 2, 0, 0, 0, 0, 21);
      pop_check("R7 last mty", 2, 0, 1, 0, 3, 22);
      chk("R2 drained", 64'(seg_valid), 64'd0);
   endtask

   task automatic t_interleave();
      push(1, 1, 0, 0, 0, 30, 0);
      push(2, 1, 0, 0, 0, 31, 0);
      push(1, 0, 1, 0, 0, 32, 0);
      push(2, 0, 1, 0, 0, 33, 0);
      chk("R6 interleave legal", 64'(ferr), 64'd0);
      pop_check("R2 il0", 1, 1, 0, 0, 0, 30);
      pop_check("R2 il1", 2, 1, 0, 0, 0, 31);
      pop_check("R2 il2", 1, 0, 1, 0, 0, 32);
      pop_check("R2 il3", 2, 0, 1, 0, 0, 33);
   endtask

   task automatic t_framing();
      push(9, 0, 1, 0, 0, 40, 0);
      chk("R6 orphan flagged", 64'(ferr), 64'd1);
      @(negedge clk);
      chk("R6 framing sticky", 64'(ferr), 64'd1);
      clear_flags();
      chk("R9 framing cleared", 64'(ferr), 64'd0);
      push(3, 1, 0, 0, 0, 41, 0);
      chk("R6 first start ok", 64'(ferr), 64'd0);
      push(3, 1, 0, 0, 0, 42, 0);
      chk("R6 reopen flagged", 64'(ferr), 64'd1);
      push(3, 0, 1, 0, 0, 43, 0);
      clear_flags();
      chk("R9 cleared again", 64'(ferr), 64'd0);
      for (int i = 0; i < 4; i++) begin
         seg_ready = 1'b1;
         @(negedge clk);
      end
      seg_ready = 1'b0;
      chk("R2 framing drained", 64'(seg_valid), 64'd0);
   endtask

   task automatic t_fill();
      for (int i = 0; i < 12; i++) push(0, 1, 1, 0, 0, 100 + i, 0);
      chk("R3 ready at 12 held", 64'(tx_ready), 64'd1);
      push(0, 1, 1, 0, 0, 112, 0);
      chk("R3 not ready at 13 held", 64'(tx_ready), 64'd0);
      chk("R4 no ovf yet", 64'(ovf), 64'd0);
      push(0, 1, 1, 0, 0, 113, 0);
      chk("R4 ovf set", 64'(ovf), 64'd1);
      push(0, 1, 1, 0, 0, 114, 0);
      push(0, 1, 1, 0, 0, 115, 0);
      // full: dropped, and a clear in the same cycle loses to the violation
      push(0, 1, 1, 0, 0, 999, 1);
      chk("R4 set wins over clear", 64'(ovf), 64'd1);
      repeat (3) @(negedge clk);
      chk("R4 ovf sticky", 64'(ovf), 64'd1);
      clear_flags();
      chk("R9 ovf cleared", 64'(ovf), 64'd0);
      for (int i = 0; i < 16; i++) begin
         pop_check("R5 drain order", 0, 1, 1, 0, 0, 100 + i);
         if (i == 3) chk("R3 ready back at 12 held", 64'(tx_ready), 64'd1);
      end
      chk("R5 dropped segment absent", 64'(seg_valid), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_single();
      t_enable_low();
      t_multi();
      t_interleave();
      t_framing();
      t_fill();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule